// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns a parallel character into a framed asynchronous serial stream on one output line. It carries its own bit-rate generator, driven by the peripheral clock: a 13-bit divisor sets a sub-bit tick, and sixteen of those ticks make one bit time. Each character goes out as a low start bit, then the data bits least significant first, then a high stop bit. The character is 8 or 9 bits wide. A hardware parity bit, odd or even, can replace the last data position.

A write strobe loads a character when the transmitter is idle. A strobe that arrives while a frame is going out is dropped. A held break request fills the line with all-zero frames. After the request is released, one high bit time follows before the transmitter becomes free again. The transmitter reports busy while it works. It raises a one-cycle done pulse when the stop bit of a character has finished.

Top module: `uart_tx_brk`

## Requirements
- R1: Out of reset, and at any time no frame or break is active, `tx` is 1 and `busy` and `done` are 0.
- R2: Every bit on `tx` lasts exactly 16 × `divisor` clock cycles, for any divisor from 1 to 8191.
- R3: A character frame is one 0 start bit, then N data bits taken from `wr_data[0]` upward (least significant first), then one 1 stop bit. N is 9 when `nine_bit` is 1 and 8 when it is 0.
- R4: With `par_en` at 1, frame position N (the last data position) carries a parity bit in place of data, and only the lower N−1 bits of `wr_data` are sent. The parity bit is chosen so that the sent data bits plus the parity bit hold an even count of ones when `par_odd` is 0, and an odd count when `par_odd` is 1.
- R5: A write (`wr_en` at 1 on a clock edge while idle) makes `busy` go high, with the start bit on `tx`, from the next cycle. A `wr_en` while `busy` is 1 has no effect on the frame in progress.
- R6: `done` is high for exactly one cycle, in the first cycle after a character's stop bit ends. `busy` falls in that same cycle.
- R7: A `brk_req` seen while idle starts a break, and it takes priority over a simultaneous write. The break sends all-zero frames of N+2 bit times each. A new zero frame follows at each frame boundary at which `brk_req` is still 1.
- R8: When a break frame ends with `brk_req` at 0, `tx` is held at 1 for one bit time while `busy` stays 1, and then the transmitter goes idle. A break never raises `done`.
- R9: While `divisor` is 0, the bit tick stops, writes and break requests are ignored, and an idle transmitter stays idle with `tx` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 13 | Bit-rate modulus; 0 stops the generator |
| nine_bit | input | 1 | 1 selects 9 data positions, 0 selects 8 |
| par_en | input | 1 | Replace the last data position with parity |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| brk_req | input | 1 | Hold high to send break frames |
| wr_en | input | 1 | Load strobe for a character |
| wr_data | input | 9 | Character to send |
| tx | output | 1 | Serial line |
| busy | output | 1 | A frame, break or break tail is in progress |
| done | output | 1 | One-cycle pulse after a character's stop bit |

## Verification
The bench sends every 8-bit value with the parity mode rotating, and a strided sweep of 9-bit values, under small divisors. It checks the line in every cycle against a frame it builds arithmetically. A design that places parity beyond the character, inverts the odd/even sense, or sends the most significant bit first shows a wrong bit at some sampled position. A design with an off-by-one in the modulus count stretches or shortens every bit, so its edges drift out of their expected cycle.

Writes injected in the middle of a frame catch a design that reloads while busy. Break holds of different lengths catch a design that gets any of these wrong: the number of zero frames, the missing high tail, a stray done pulse, or a write winning over a break. A zero divisor with both strobes pulsed catches a design that starts a frame it can never finish.

// File: rtl/utx_pkg.sv
package utx_pkg;
    // Sub-bit ticks per bit time.
    localparam int OVS = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DATA  = 2'd1,
        ST_BREAK = 2'd2,
        ST_TAIL  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/utx_baud.sv
module utx_baud #(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_tick
);
    localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [SUB_W-1:0] sub;
    } baud_st_t;

    baud_st_t st_d, st_q;
    logic     sub_tick;
    logic     div_zero;

    always_comb begin
        st_d     = st_q;
        div_zero = (divisor == '0);
        sub_tick = run && !div_zero && (st_q.pre == divisor - DIV_W'(1));
        bit_tick = sub_tick && (st_q.sub == SUB_W'(OVS - 1));
        if (!run || div_zero) begin
            st_d = '0;
        end else if (sub_tick) begin
            st_d.pre = '0;
            st_d.sub = (st_q.sub == SUB_W'(OVS - 1)) ? '0 : st_q.sub + SUB_W'(1);
        end else begin
            st_d.pre = st_q.pre + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: no tick when the divisor is zero or the generator is stopped
    p_tick_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> (run && divisor != '0));

    // R2: the modulus counter never passes the divisor
    p_pre_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && divisor != '0 && $stable(divisor)) |-> (st_q.pre < divisor));
endmodule

// File: rtl/utx_framer.sv
module utx_framer
    import utx_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              div_ok,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk_req,
    output logic              tx,
    output logic              busy,
    output logic              done
);
    localparam int FRM_W = DATA_W + 2;
    localparam int CNT_W = $clog2(FRM_W + 1);

    typedef struct packed {
        tx_state_e        st;
        logic [FRM_W-1:0] shreg;
        logic [CNT_W-1:0] left;
        logic             done;
    } frm_st_t;

    frm_st_t          st_d, st_q;
    logic [FRM_W-1:0] char_frame;
    logic [CNT_W-1:0] frame_len;
    logic             par_bit;
    int               n_pos;
    int               n_dat;

    // Character frame image, least significant bit leaves first.
    always_comb begin
        n_pos      = nine_bit ? DATA_W : DATA_W - 1;
        n_dat      = par_en ? n_pos - 1 : n_pos;
        frame_len  = CNT_W'(n_pos + 2);
        char_frame = '1;
        char_frame[0] = 1'b0;
        par_bit    = par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < n_dat) begin
                char_frame[i+1] = wr_data[i];
                par_bit         = par_bit ^ wr_data[i];
            end
        end
        if (par_en) char_frame[n_pos] = par_bit;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (div_ok && brk_req) begin
                    st_d.st    = ST_BREAK;
                    st_d.shreg = '0;
                    st_d.left  = frame_len;
                end else if (div_ok && wr_en) begin
                    st_d.st    = ST_DATA;
                    st_d.shreg = char_frame;
                    st_d.left  = frame_len;
                end
            end
            default: begin
                if (bit_tick) begin
                    if (st_q.left == CNT_W'(1)) begin
                        if (st_q.st == ST_BREAK && brk_req) begin
                            st_d.shreg = '0;
                            st_d.left  = frame_len;
                        end else if (st_q.st == ST_BREAK) begin
                            st_d.st    = ST_TAIL;
                            st_d.shreg = '1;
                            st_d.left  = CNT_W'(1);
                        end else begin
                            st_d.done  = (st_q.st == ST_DATA);
                            st_d.st    = ST_IDLE;
                            st_d.shreg = '1;
                            st_d.left  = '0;
                        end
                    end else begin
                        st_d.shreg = {1'b1, st_q.shreg[FRM_W-1:1]};
                        st_d.left  = st_q.left - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.st    <= ST_IDLE;
            st_q.shreg <= '1;
            st_q.left  <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.st != ST_IDLE);
    assign tx   = busy ? st_q.shreg[0] : 1'b1;
    assign done = st_q.done;

    // R1: line high whenever idle
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);
    // R2: line and activity hold between bit ticks
    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_tick) |=> (busy && $stable(tx)));
    // R3: every frame or break opens low
    p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx);
    // R6: done lasts one cycle and coincides with the busy fall
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R8: the break tail is high
    p_tail_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_TAIL) |-> tx);
    // R9: no start without a working divisor
    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_ok && !busy) |=> !busy);
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
    parameter int DIV_W  = 13,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              nine_bit,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              brk_req,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx,
    output logic              busy,
    output logic              done
);
    logic bit_tick;
    logic div_ok;

    assign div_ok = (divisor != '0);

    utx_baud #(.DIV_W(DIV_W), .OVS(utx_pkg::OVS)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .divisor  (divisor),
        .bit_tick (bit_tick)
    );

    utx_framer #(.DATA_W(DATA_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .div_ok   (div_ok),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .nine_bit (nine_bit),
        .par_en   (par_en),
        .par_odd  (par_odd),
        .brk_req  (brk_req),
        .tx       (tx),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: tb/tb_uart_tx_brk.sv
module tb_uart_tx_brk;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] divisor = 13'd1;
    logic        nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic        brk_req = 1'b0, wr_en = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        tx, busy, done;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    uart_tx_brk dut (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .nine_bit(nine_bit),
        .par_en(par_en), .par_odd(par_odd), .brk_req(brk_req), .wr_en(wr_en),
        .wr_data(wr_data), .tx(tx), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [8:0] d, input logic nine,
                                              input logic pe, input logic po);
        int   npos = nine ? 9 : 8;
        int   ndat = pe ? npos - 1 : npos;
        logic ones = 1'b0;
        logic [10:0] f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < ndat; i++) begin
            f[i+1] = d[i];
            ones   = ones ^ d[i];
        end
        if (pe) f[npos] = ones ^ po;
        return f;
    endfunction

    // R3 R4 R5 R6 R2: send one character and check every cycle of it
    task automatic send(input logic [8:0] d, input logic nine, input logic pe,
                        input logic po, input int dv, input logic poke);
        logic [10:0] f = exp_frame(d, nine, pe, po);
        int bt = 16 * dv;
        int len = nine ? 11 : 10;
        int tot = len * bt;
        @(negedge clk);
        divisor = 13'(dv); nine_bit = nine; par_en = pe; par_odd = po;
        wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c <= tot + 1; c++) begin
            if (c < tot) begin
                chk(busy === 1'b1, "R5 busy", int'(busy), 1);
                chk(tx === f[c / bt], "R3/R4 tx bit", int'(tx), int'(f[c / bt]));
                chk(done === 1'b0, "R6 done early", int'(done), 0);
            end else if (c == tot) begin
                chk(busy === 1'b0, "R2 busy fall", int'(busy), 0);
                chk(done === 1'b1, "R6 done pulse", int'(done), 1);
                chk(tx === 1'b1, "R1 idle line", int'(tx), 1);
            end else begin
                chk(done === 1'b0, "R6 done width", int'(done), 0);
            end
            if (poke && c == 20) begin
                wr_data = ~d; wr_en = 1'b1;   // R5: ignored while busy
                nine_bit = ~nine; par_en = ~pe;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        nine_bit = nine; par_en = pe;
    endtask

    // R7 R8: break held so that brk_req is seen on `hold` edges
    task automatic brk(input int dv, input logic nine, input int hold);
        int bt = 16 * dv;
        int fl = (nine ? 11 : 10) * bt;
        int nfr = 1 + (hold - 1) / fl;
        int tot = nfr * fl + bt;
        @(negedge clk);
        divisor = 13'(dv); nine_bit = nine;
        brk_req = 1'b1; wr_en = 1'b1; wr_data = 9'h1FF;   // R7: break wins
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c <= tot; c++) begin
            if (c < nfr * fl) begin
                chk(tx === 1'b0, "R7 break low", int'(tx), 0);
                chk(busy === 1'b1, "R7 busy", int'(busy), 1);
            end else if (c < tot) begin
                chk(tx === 1'b1, "R8 tail high", int'(tx), 1);
                chk(busy === 1'b1, "R8 tail busy", int'(busy), 1);
            end else begin
                chk(busy === 1'b0, "R8 idle after tail", int'(busy), 0);
                chk(tx === 1'b1, "R1 idle line", int'(tx), 1);
            end
            chk(done === 1'b0, "R8 no done", int'(done), 0);
            if (c == hold - 1) brk_req = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        chk(tx === 1'b1, "R1 reset tx", int'(tx), 1);
        chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        chk(done === 1'b0, "R1 reset done", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // 8-bit values exhaustive, parity mode rotating
        for (int v = 0; v < 256; v++)
            send(9'(v), 1'b0, logic'(v[0] ^ v[3]), logic'(v[1]), 1, logic'(v % 7 == 0));
        // 9-bit strided sweep
        for (int v = 0; v < 512; v += 4)
            send(9'(v + (v >> 3)), 1'b1, logic'(v[2] | v[5]), logic'(v[3]), 1, logic'(v % 12 == 0));
        // larger divisors
        send(9'h0A5, 1'b0, 1'b0, 1'b0, 2, 1'b1);
        send(9'h15A, 1'b1, 1'b1, 1'b1, 3, 1'b0);
        send(9'h0FF, 1'b0, 1'b1, 1'b0, 5, 1'b0);

        // breaks: single frame, two frames, boundary hold
        brk(1, 1'b0, 1);
        brk(1, 1'b0, 165);
        brk(2, 1'b1, 352);
        brk(2, 1'b1, 353);

        // R9: zero divisor
        @(negedge clk);
        divisor = '0; wr_en = 1'b1; brk_req = 1'b1; wr_data = 9'h055;
        @(negedge clk);
        wr_en = 1'b0;
        for (int c = 0; c < 40; c++) begin
            chk(busy === 1'b0, "R9 stays idle", int'(busy), 0);
            chk(tx === 1'b1, "R9 line high", int'(tx), 1);
            @(negedge clk);
        end
        brk_req = 1'b0;
        send(9'h033, 1'b0, 1'b0, 1'b0, 1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule